// File: doc/BRIEF.md
# Piecewise Nonlinear Function Evaluator

This block approximates an arbitrary nonlinear curve of a 12-bit unsigned fixed-point sample. The input range is split into sixteen intervals by fifteen programmable thresholds, and the thresholds need not be evenly spaced. Each interval has a table entry with a signed slope and an unsigned base value. Each sample carries its own mode bit. In linear mode the result is the slope times the input plus the base, rounded and clamped to the 12-bit output range. In constant mode the base value is the result and the multiplier is bypassed.

Evaluation runs in three registered stages: threshold comparison, table read, then multiply-add or bypass. Results come out in input order, exactly three cycles after the sample is accepted, and a new sample may enter on every cycle in either mode. Thresholds and table entries are loaded through a single write port. A write takes effect only while no sample is in flight.

Top module: `pwl_eval`

## Requirements
- R1: After reset, `out_valid` and `out_data` are 0. Threshold k (k = 0..14) resets to (k+1)*256, so the reset intervals are uniform. Every table entry resets to zero.
- R2: With ascending thresholds, the interval index is the number of thresholds less than or equal to the sample. A sample equal to a threshold therefore falls into the upper interval.
- R3: In linear mode (`in_mode_const` = 0) the result is base + floor((slope*x + 128) / 256). The slope is two's complement in Q4.8 and is held in table word bits [23:12]. The base is unsigned and is held in bits [11:0].
- R4: A linear result below 0 is output as 0, and a result above 4095 is output as 4095.
- R5: In constant mode (`in_mode_const` = 1) the output is the base field of the selected entry, and the slope field has no effect.
- R6: A sample accepted on a clock edge produces `out_valid` exactly three edges later in both modes, with one result per accepted sample, in order.
- R7: With `cfg_sel_tbl` = 0 a write loads threshold `cfg_addr` from `cfg_wdata[11:0]`, and address 15 is ignored. With `cfg_sel_tbl` = 1 a write loads table entry `cfg_addr` with all 24 bits.
- R8: A configuration write is dropped if `in_valid` is high or any earlier sample is still in the first two stages.
- R9: The mode travels with each sample, so back-to-back samples of mixed modes each get their own mode's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | 12 | Unsigned input sample |
| in_mode_const | input | 1 | 1 = constant mode, 0 = linear mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel_tbl | input | 1 | 0 = threshold write, 1 = table write |
| cfg_addr | input | 4 | Threshold or table index |
| cfg_wdata | input | 24 | Write data: slope [23:12], base [11:0]; thresholds use [11:0] |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 12 | Evaluated result |

## Verification
The bench builds the block with its default parameters: 12-bit samples, four index bits (sixteen intervals) and Q4.8 slopes. At these sizes a reference model can sweep the whole 0..4095 range. The bench also places samples exactly on and one below thresholds at both ends of the range. It drives slopes of both signs so that the clamp is reached at both limits, and it hits the half-LSB rounding point exactly. The same sizes let the bench attempt writes in each busy cycle of a three-deep pipeline and observe that the dropped write leaves later results unchanged.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

  localparam int unsigned PWL_DATA_W     = 12;
  localparam int unsigned PWL_IDX_W      = 4;
  localparam int unsigned PWL_SLOPE_W    = 12;
  localparam int unsigned PWL_SLOPE_FRAC = 8;
  localparam int unsigned PWL_ACC_W      = 48;

  typedef enum logic {
    MODE_LINEAR = 1'b0,
    MODE_CONST  = 1'b1
  } pwl_mode_e;

  // Affine step: base + floor((slope*x + half) / 2^frac), unclamped.
  function automatic logic signed [PWL_ACC_W-1:0] pwl_affine(
    input logic signed [PWL_ACC_W-1:0] slope,
    input logic signed [PWL_ACC_W-1:0] x,
    input logic signed [PWL_ACC_W-1:0] base,
    input int unsigned                 frac
  );
    logic signed [PWL_ACC_W-1:0] prod;
    logic signed [PWL_ACC_W-1:0] half;
    prod = slope * x;
    half = (frac == 0) ? '0 : (PWL_ACC_W'(1) <<< (frac - 1));
    return ((prod + half) >>> frac) + base;
  endfunction

endpackage

// File: rtl/pwl_bkpt_cmp.sv
module pwl_bkpt_cmp
  import pwl_pkg::*;
#(
  parameter int unsigned DATA_W = PWL_DATA_W,
  parameter int unsigned IDX_W  = PWL_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_x,
  input  pwl_mode_e         in_mode,
  output logic              s1_valid,
  output logic [DATA_W-1:0] s1_x,
  output pwl_mode_e         s1_mode,
  output logic [IDX_W-1:0]  s1_idx
);

  localparam int unsigned NUM_BKPT = (1 << IDX_W) - 1;
  localparam int unsigned STEP_SH  = DATA_W - IDX_W;

  logic [DATA_W-1:0]          bkpt_q [NUM_BKPT];
  logic [NUM_BKPT*DATA_W-1:0] bkpt_flat;
  logic [NUM_BKPT-1:0]        at_or_above;
  logic [IDX_W-1:0]           idx_d;

  for (genvar k = 0; k < NUM_BKPT; k++) begin : g_bkpt
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'((k + 1) << STEP_SH);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bkpt_q[k] <= RST_VAL;
      end else if (wr_en && (wr_addr == IDX_W'(k))) begin
        bkpt_q[k] <= wr_data;
      end
    end
    assign at_or_above[k] = (in_x >= bkpt_q[k]);
    assign bkpt_flat[k*DATA_W +: DATA_W] = bkpt_q[k];
  end

  // Interval index = number of thresholds at or below the sample.
  always_comb begin
    idx_d = '0;
    for (int k = 0; k < NUM_BKPT; k++) begin
      idx_d = idx_d + IDX_W'(at_or_above[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_x     <= '0;
      s1_mode  <= MODE_LINEAR;
      s1_idx   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_x    <= in_x;
        s1_mode <= in_mode;
        s1_idx  <= idx_d;
      end
    end
  end

  // R2: the chosen interval brackets the sample (thresholds cannot move while busy)
  assert_idx_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_idx != IDX_W'(NUM_BKPT))) |->
      (s1_x < bkpt_flat[int'(s1_idx)*DATA_W +: DATA_W]));

  assert_idx_lower_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_idx != '0)) |->
      (s1_x >= bkpt_flat[(int'(s1_idx) - 1)*DATA_W +: DATA_W]));

  // R8: a sample entering blocks threshold updates on that edge
  assert_bkpt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> $stable(bkpt_flat));

endmodule

// File: rtl/pwl_seg_table.sv
module pwl_seg_table
  import pwl_pkg::*;
#(
  parameter int unsigned DATA_W  = PWL_DATA_W,
  parameter int unsigned IDX_W   = PWL_IDX_W,
  parameter int unsigned SLOPE_W = PWL_SLOPE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_addr,
  input  logic [SLOPE_W+DATA_W-1:0] wr_data,
  input  logic                      s1_valid,
  input  logic [DATA_W-1:0]         s1_x,
  input  pwl_mode_e                 s1_mode,
  input  logic [IDX_W-1:0]          s1_idx,
  output logic                      s2_valid,
  output logic [DATA_W-1:0]         s2_x,
  output pwl_mode_e                 s2_mode,
  output logic signed [SLOPE_W-1:0] s2_slope,
  output logic [DATA_W-1:0]         s2_base
);

  localparam int unsigned NUM_SEG = 1 << IDX_W;
  localparam int unsigned ENTRY_W = SLOPE_W + DATA_W;

  logic [ENTRY_W-1:0]         tbl_q [NUM_SEG];
  logic [NUM_SEG*ENTRY_W-1:0] tbl_flat;
  logic [ENTRY_W-1:0]         entry_rd;

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_q[k] <= '0;
      end else if (wr_en && (wr_addr == IDX_W'(k))) begin
        tbl_q[k] <= wr_data;
      end
    end
    assign tbl_flat[k*ENTRY_W +: ENTRY_W] = tbl_q[k];
  end

  assign entry_rd = tbl_q[s1_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_x     <= '0;
      s2_mode  <= MODE_LINEAR;
      s2_slope <= '0;
      s2_base  <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_x     <= s1_x;
        s2_mode  <= s1_mode;
        s2_slope <= $signed(entry_rd[ENTRY_W-1:DATA_W]);
        s2_base  <= entry_rd[DATA_W-1:0];
      end
    end
  end

  // R8: a sample in the compare stage blocks table updates on that edge
  assert_tbl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> $stable(tbl_flat));

  // R9: the mode and sample advance unchanged into the lookup stage
  assert_mode_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> (s2_mode == $past(s1_mode)) && (s2_x == $past(s1_x)));

endmodule

// File: rtl/pwl_mac_stage.sv
module pwl_mac_stage
  import pwl_pkg::*;
#(
  parameter int unsigned DATA_W     = PWL_DATA_W,
  parameter int unsigned SLOPE_W    = PWL_SLOPE_W,
  parameter int unsigned SLOPE_FRAC = PWL_SLOPE_FRAC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      s2_valid,
  input  logic [DATA_W-1:0]         s2_x,
  input  pwl_mode_e                 s2_mode,
  input  logic signed [SLOPE_W-1:0] s2_slope,
  input  logic [DATA_W-1:0]         s2_base,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_data
);

  localparam int unsigned ACC_W = PWL_ACC_W;
  localparam logic signed [ACC_W-1:0] MAX_V = (ACC_W'(1) <<< DATA_W) - ACC_W'(1);

  logic signed [ACC_W-1:0] lin_raw;
  logic                    lin_under;
  logic                    lin_over;
  logic [DATA_W-1:0]       lin_clip;
  logic [DATA_W-1:0]       result_d;

  assign lin_raw = pwl_affine(
    $signed({{(ACC_W-SLOPE_W){s2_slope[SLOPE_W-1]}}, s2_slope}),
    $signed({{(ACC_W-DATA_W){1'b0}}, s2_x}),
    $signed({{(ACC_W-DATA_W){1'b0}}, s2_base}),
    SLOPE_FRAC);

  assign lin_under = (lin_raw < 0);
  assign lin_over  = (lin_raw > MAX_V);

  always_comb begin
    if (lin_under)     lin_clip = '0;
    else if (lin_over) lin_clip = '1;
    else               lin_clip = lin_raw[DATA_W-1:0];
  end

  // Constant mode skips the product; the register below keeps latency equal.
  assign result_d = (s2_mode == MODE_CONST) ? s2_base : lin_clip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) out_data <= result_d;
    end
  end

  // R6: results emerge one edge after the lookup stage
  assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s2_valid));

  // R4: clamp at both limits
  assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && (s2_mode == MODE_LINEAR) && lin_under) |=> (out_data == '0));

  assert_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && (s2_mode == MODE_LINEAR) && lin_over) |=> (out_data == '1));

  // R5: constant mode passes the stored base untouched
  assert_const_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && (s2_mode == MODE_CONST)) |=> (out_data == $past(s2_base)));

endmodule

// File: rtl/pwl_eval.sv
module pwl_eval
  import pwl_pkg::*;
#(
  parameter int unsigned DATA_W     = PWL_DATA_W,
  parameter int unsigned IDX_W      = PWL_IDX_W,
  parameter int unsigned SLOPE_W    = PWL_SLOPE_W,
  parameter int unsigned SLOPE_FRAC = PWL_SLOPE_FRAC
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         in_sample,
  input  logic                      in_mode_const,
  input  logic                      cfg_we,
  input  logic                      cfg_sel_tbl,
  input  logic [IDX_W-1:0]          cfg_addr,
  input  logic [SLOPE_W+DATA_W-1:0] cfg_wdata,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_data
);

  logic                      s1_valid;
  logic [DATA_W-1:0]         s1_x;
  pwl_mode_e                 s1_mode;
  logic [IDX_W-1:0]          s1_idx;
  logic                      s2_valid;
  logic [DATA_W-1:0]         s2_x;
  pwl_mode_e                 s2_mode;
  logic signed [SLOPE_W-1:0] s2_slope;
  logic [DATA_W-1:0]         s2_base;

  logic pipe_idle;
  logic cfg_accept;
  logic bkpt_wr;
  logic tbl_wr;

  // Writes land only when nothing is entering or inside the first two stages.
  assign pipe_idle  = !in_valid && !s1_valid && !s2_valid;
  assign cfg_accept = cfg_we && pipe_idle;
  assign bkpt_wr    = cfg_accept && !cfg_sel_tbl;
  assign tbl_wr     = cfg_accept && cfg_sel_tbl;

  pwl_bkpt_cmp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bkpt_wr),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata[DATA_W-1:0]),
    .in_valid (in_valid),
    .in_x     (in_sample),
    .in_mode  (pwl_mode_e'(in_mode_const)),
    .s1_valid (s1_valid),
    .s1_x     (s1_x),
    .s1_mode  (s1_mode),
    .s1_idx   (s1_idx)
  );

  pwl_seg_table #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SLOPE_W(SLOPE_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_wr),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .s1_valid (s1_valid),
    .s1_x     (s1_x),
    .s1_mode  (s1_mode),
    .s1_idx   (s1_idx),
    .s2_valid (s2_valid),
    .s2_x     (s2_x),
    .s2_mode  (s2_mode),
    .s2_slope (s2_slope),
    .s2_base  (s2_base)
  );

  pwl_mac_stage #(.DATA_W(DATA_W), .SLOPE_W(SLOPE_W), .SLOPE_FRAC(SLOPE_FRAC)) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .s2_valid  (s2_valid),
    .s2_x      (s2_x),
    .s2_mode   (s2_mode),
    .s2_slope  (s2_slope),
    .s2_base   (s2_base),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // R6: an accepted sample reaches the lookup stage two edges later
  assert_stage_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> s2_valid);

endmodule

// File: tb/tb_pwl_eval.sv
module tb_pwl_eval;

  localparam int DW = 12;
  localparam int NB = 15;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_sample = '0;
  logic        in_mode_const = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel_tbl = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic        out_valid;
  logic [11:0] out_data;

  always #4 clk = ~clk;

  pwl_eval dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_mode_const(in_mode_const), .cfg_we(cfg_we), .cfg_sel_tbl(cfg_sel_tbl),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_data(out_data)
  );

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int bk[NB];
  int tslope[NS];
  int tbase[NS];

  typedef struct { int v; int c; string t; } exp_t;
  exp_t sb[$];

  // Reference: own floor division, own clamp.
  function automatic int model(int x, bit c);
    int idx = 0;
    int num, q, v;
    for (int k = 0; k < NB; k++) if (x >= bk[k]) idx++;
    if (c) return tbase[idx];
    num = tslope[idx] * x + 128;
    if (num >= 0) q = num / 256;
    else          q = -((-num + 255) / 256);
    v = q + tbase[idx];
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(int x, bit c, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = 12'(x);
    in_mode_const = c;
    e.v = model(x, c); e.c = cyc; e.t = tag;
    sb.push_back(e);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic wcfg(bit t, int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel_tbl = t; cfg_addr = 4'(a); cfg_wdata = 24'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wtbl(int a, int slope, int base);
    wcfg(1'b1, a, ((slope & 'hFFF) << 12) | (base & 'hFFF));
    tslope[a] = slope;
    tbase[a] = base;
  endtask

  task automatic wbk(int a, int v);
    wcfg(1'b0, a, v);
    if (a < NB) bk[a] = v;
  endtask

  // Write held across the three busy edges; the model is left unchanged.
  task automatic busy_write(bit t, int a, int d, int x, bit c, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_sample = 12'(x); in_mode_const = c;
    cfg_we = 1'b1; cfg_sel_tbl = t; cfg_addr = 4'(a); cfg_wdata = 24'(d);
    e.v = model(x, c); e.c = cyc; e.t = tag;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 50000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Scoreboard monitor: value and R6 latency.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R6 output with no pending sample", int'(out_data), -1);
      end else begin
        e = sb.pop_front();
        chk(out_data == 12'(e.v), e.t, int'(out_data), e.v);
        chk((cyc - e.c) == 3, "R6 latency", cyc - e.c, 3);
      end
    end
  end

  int grid[9] = '{0, 255, 256, 511, 512, 2048, 3839, 3840, 4095};
  int bvals[NB] = '{10, 20, 50, 100, 200, 400, 700, 1000, 1500, 2000, 2500, 3000, 3500, 3900, 4000};

  initial begin
    for (int k = 0; k < NB; k++) bk[k] = (k + 1) * 256;
    for (int k = 0; k < NS; k++) begin tslope[k] = 0; tbase[k] = 0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(out_data == '0, "R1 out_data after reset", int'(out_data), 0);

    send(1000, 1'b0, "R1 zero table linear");
    send(3000, 1'b1, "R1 zero table const");
    drain();

    for (int k = 0; k < NS; k++) wtbl(k, 64 * k - 300, 17 * k + 3);
    foreach (grid[i]) send(grid[i], 1'b1, "R1 reset breakpoints const");
    foreach (grid[i]) send(grid[i], 1'b0, "R3 linear on reset grid");
    drain();

    for (int k = 0; k < NB; k++) wbk(k, bvals[k]);
    wtbl(0, 256, 5);
    wtbl(3, 1, 7);
    wtbl(4, 1, 7);
    wtbl(6, -256, 1000);
    wtbl(7, -512, 100);
    wtbl(8, 2047, 4095);
    wtbl(9, 384, 0);
    wtbl(14, -1, 0);
    wtbl(15, 256, 0);

    send(9, 1'b1, "R2 below first threshold");
    send(10, 1'b1, "R2 tie goes up");
    send(19, 1'b1, "R2 one below threshold");
    send(20, 1'b1, "R2 tie goes up");
    send(3999, 1'b1, "R2 one below last threshold");
    send(4000, 1'b1, "R2 tie on last threshold");
    send(4095, 1'b1, "R2 top of range");
    drain();

    send(3, 1'b0, "R3 unit slope");
    send(64, 1'b0, "R3 round down");
    send(127, 1'b0, "R3 just under half");
    send(128, 1'b0, "R3 exact half rounds up");
    send(199, 1'b0, "R3 round");
    send(500, 1'b0, "R3 negative slope");
    send(1501, 1'b0, "R3 fractional slope");
    send(800, 1'b0, "R4 clamp low");
    send(1200, 1'b0, "R4 clamp high");
    send(3950, 1'b0, "R4 small negative clamps to 0");
    send(4095, 1'b0, "R4 exact max no clamp");
    send(1200, 1'b1, "R5 const ignores slope");
    send(800, 1'b1, "R5 const ignores slope");
    drain();

    for (int i = 0; i < 40; i++) send((i * 103 + 7) % 4096, 1'(i % 2), "R9 mixed stream");
    for (int i = 0; i < 16; i++) send(i * 273, 1'(i % 3 == 0), "R6 back-to-back");
    drain();

    wbk(15, 0);
    send(4095, 1'b1, "R7 threshold addr 15 ignored");
    send(3999, 1'b1, "R7 threshold addr 15 ignored");
    drain();
    wtbl(2, 0, 1234);
    send(30, 1'b1, "R7 table write applied");
    drain();

    busy_write(1'b1, 3, (5 << 12) | 3333, 60, 1'b1, "R8 sample during busy writes");
    busy_write(1'b0, 3, 55, 70, 1'b0, "R8 sample during busy writes");
    send(60, 1'b1, "R8 busy table write dropped");
    send(60, 1'b0, "R8 busy threshold write dropped");
    drain();

    chk(sb.size() == 0, "R6 all results delivered", sb.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule